// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

This block is a serial peripheral interface host with a small word-oriented register bus. Software picks a configuration, loads transmit words into a four-entry queue and then switches the block into its running mode. The serial engine sends each queued word on the clock and data-out pins. At the same time it collects the bits arriving on data-in, and the finished words go into a second four-entry queue for software to read back. Chip selects are not part of this block: the surrounding system drives them from general-purpose outputs.

The word length is 8 or 16 bits. The clock divider, idle clock level, sampling phase, bit order and an optional idle spacing between consecutive words are all programmable. A level-sensitive interrupt is raised when the receive queue holds at least a programmed number of words, from one to four. A sticky overrun flag records a completed word that was lost because the receive queue was full.

The serial engine is a three-state machine:
- IDLE: the clock rests at its idle level and data-out is low.
- SHIFT: one word is being clocked.
- GAP: the optional spacing between words is being counted.

It has these transitions:
- IDLE to SHIFT, called start: the mode is running, no stop is requested and a transmit word is waiting. The word is popped on this cycle.
- SHIFT to SHIFT: the engine advances one bit at the end of each clock period.
- SHIFT to GAP, called word end with spacing: the last bit period ends and the spacing value is non-zero.
- SHIFT to IDLE, called word end without spacing: the last bit period ends and the spacing value is zero.
- GAP to IDLE, called spacing done: the spacing count has run out.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset these values hold:
  - Mode control (offset 0x00) reads 0x40, which is configuration mode.
  - Clock/length (offset 0x08) reads 0x0108.
  - Status (offset 0x14) reads 0x8006.
  - `irq` and `sck` are low.
- R2: The clock/length register (offset 0x08) holds the divider n in bits [15:8] and the word length in bits [4:0]. A length value of 16 selects 16-bit words and any other value selects 8-bit words. A write to it takes effect only while the mode field is configuration (01). At any other time the write leaves the read-back value unchanged.
- R3: Mode control bits [7:6] select the mode: 01 is configuration and 10 is running. Bit 1 is a stop request. A word starts shifting only while the mode is 10 and the stop bit is 0. Otherwise queued words stay in the transmit queue and `sck` does not toggle.
- R4: One bit takes n+1 base clock cycles, so `sck` rises once every n+1 cycles within a word. A divider of 0 behaves as a divider of 1.
- R5: Control register (offset 0x04) bit 0 sets the idle level of `sck`. Bit 1 sets the phase:
  - With bit 1 at 0, `mosi` changes only on trailing clock edges and data is sampled on leading edges.
  - With bit 1 at 1, `mosi` changes on leading edges and data is sampled on trailing edges.
- R6: When control bit 2 is 1, words go out most significant bit first. When it is 0, they go out least significant bit first. In 8-bit mode only bits [7:0] of a written word are sent.
- R7: Each received word is right-aligned in the data register with the unused upper bits zero. With `miso` tied to `mosi`, the word read back equals the word sent.
- R8: Writing the data register (offset 0x18) pushes a transmit word and reading it pops the oldest receive word. Each queue holds four words. A push into a full transmit queue is discarded. Status bits [13:11] give the transmit count and bits [10:8] the receive count.
- R9: Control bits [13:12] hold the receive level minus one. Status bit 14 is 1 exactly while the receive count is at least that level. `irq` is status bit 14 ANDed with control bit 9.
- R10: A word that completes while the receive queue is full is discarded, and status bit 7 is set. The bit stays set until a queue clear.
- R11: Writing mode control with bit 0 set empties both queues and clears status bit 7.
- R12: Status bit 2 is 1 when the engine is in IDLE and the transmit queue is empty. Bit 1 is 1 when the transmit queue is not full. Bit 0 is 1 when the receive queue is not empty. Bit 15 is 1 when the transmit count is at most control bits [15:14].
- R13: The spacing register (offset 0x0C) holds a count F in bits [7:0]. Between back-to-back words, the distance from the last rising `sck` edge of one word to the first rising edge of the next is (n+1)+F+1 cycles when the clock idles low with phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while bus_sel is high |
| irq | output | 1 | Receive-level interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The embedded properties assume the following about the inputs:
- Each register access is a single-cycle strobe.
- Software writes the clock/length register only as the configuration permits.
- The polarity, phase and order bits do not change while a word is in flight.

The directed stimulus keeps to these limits. Every setting change happens in configuration mode after the engine has gone idle, and accesses are issued at the falling edge, one cycle apart. `miso` is looped back from `mosi`, so received data is predictable. Overrun is reached only by deliberately leaving received words unread.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_CONFIG = 2'b01,
        MODE_ACTIVE = 2'b10,
        MODE_BOTH   = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_e;

    localparam logic [4:0] OFF_MCTL  = 5'h00;
    localparam logic [4:0] OFF_CTL0  = 5'h04;
    localparam logic [4:0] OFF_CTL1  = 5'h08;
    localparam logic [4:0] OFF_SPACE = 5'h0C;
    localparam logic [4:0] OFF_STAT  = 5'h14;
    localparam logic [4:0] OFF_DATA  = 5'h18;

    typedef struct packed {
        logic       msb_first;
        logic       cpha;
        logic       cpol;
        logic       wide;
        logic [7:0] div;
        logic [7:0] space;
    } eng_cfg_t;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rp];
    assign count   = cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (cnt == $past(cnt)));

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
#(
    parameter int MAXW = 16,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  eng_cfg_t        cfg,
    input  logic            tx_avail,
    input  logic [MAXW-1:0] tx_word,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [MAXW-1:0] rx_word,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic            idle
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int BW = $clog2(MAXW);
    localparam int NW = MAXW / 2;

    eng_state_e      state, state_n;
    logic [DIVW-1:0] cnt;
    logic [BW-1:0]   bitn;
    logic [MAXW-1:0] tsh, rsh, rx_next;
    logic [7:0]      gcnt;
    logic [DIVW-1:0] div_eff;
    logic [DIVW:0]   half_w;
    logic [DIVW-1:0] half;
    logic [BW-1:0]   last;
    logic            start, sample, bit_end, word_end;

    assign div_eff  = (cfg.div == '0) ? DIVW'(1) : cfg.div;
    assign half_w   = ({1'b0, div_eff} + 1'b1) >> 1;
    assign half     = half_w[DIVW-1:0];
    assign last     = cfg.wide ? BW'(MAXW-1) : BW'(NW-1);

    assign start    = (state == ENG_IDLE) && run && tx_avail;
    assign sample   = (state == ENG_SHIFT) && (cnt == half);
    assign bit_end  = (state == ENG_SHIFT) && (cnt == div_eff);
    assign word_end = bit_end && (bitn == last);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ENG_IDLE:  if (start) state_n = ENG_SHIFT;
            ENG_SHIFT: if (word_end) state_n = (cfg.space != '0) ? ENG_GAP : ENG_IDLE;
            ENG_GAP:   if (gcnt == '0) state_n = ENG_IDLE;
            default:   state_n = ENG_IDLE;
        endcase
    end

    // received bit merge
    always_comb begin
        if (cfg.msb_first) rx_next = {rsh[MAXW-2:0], miso};
        else               rx_next = {miso, rsh[MAXW-1:1]};
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
            tsh  <= '0;
            rsh  <= '0;
            gcnt <= '0;
        end else begin
            if (start) begin
                tsh  <= tx_word;
                rsh  <= '0;
                cnt  <= '0;
                bitn <= '0;
            end else if (state == ENG_SHIFT) begin
                if (sample) rsh <= rx_next;
                if (bit_end) begin
                    cnt  <= '0;
                    bitn <= bitn + 1'b1;
                    tsh  <= cfg.msb_first ? (tsh << 1) : (tsh >> 1);
                end else begin
                    cnt <= cnt + 1'b1;
                end
                if (word_end) gcnt <= cfg.space - 1'b1;
            end else if (state == ENG_GAP) begin
                gcnt <= gcnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_pop  = start;
        rx_push = sample && (bitn == last);
        rx_word = (!cfg.msb_first && !cfg.wide) ? (rx_next >> NW) : rx_next;
        idle    = (state == ENG_IDLE);
        if (state == ENG_SHIFT) begin
            sck  = cfg.cpol ^ ((cnt < half) ? cfg.cpha : ~cfg.cpha);
            mosi = cfg.msb_first ? tsh[last] : tsh[0];
        end else begin
            sck  = cfg.cpol;
            mosi = 1'b0;
        end
    end

    // R6
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_SHIFT) |-> (bitn <= last));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_SHIFT) |-> (cnt <= div_eff));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int WORD_MAX   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sck,
    output logic        mosi,
    input  logic        miso
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = $clog2(FIFO_DEPTH+1);

    op_mode_e           mode;
    logic               stop_req;
    logic [15:0]        ctl0;
    logic [7:0]         div;
    logic               wide;
    logic [7:0]         space;
    logic               ovr;

    logic               wr_en, rd_en, clr;
    logic               tx_push, tx_pop, tx_full, tx_empty;
    logic               rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_MAX-1:0] tx_dout, rx_dout, rx_word;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    logic               eng_idle, run;
    logic               rx_flag, tx_flag;
    logic [2:0]         tx_cnt3, rx_cnt3;
    eng_cfg_t           cfg;

    assign wr_en   = bus_sel && bus_wr;
    assign rd_en   = bus_sel && !bus_wr;
    assign clr     = wr_en && (bus_addr == OFF_MCTL) && bus_wdata[0];
    assign tx_push = wr_en && (bus_addr == OFF_DATA);
    assign rx_pop  = rd_en && (bus_addr == OFF_DATA);
    assign run     = (mode == MODE_ACTIVE) && !stop_req;

    assign cfg.msb_first = ctl0[2];
    assign cfg.cpha      = ctl0[1];
    assign cfg.cpol      = ctl0[0];
    assign cfg.wide      = wide;
    assign cfg.div       = div;
    assign cfg.space     = space;

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= MODE_CONFIG;
            stop_req <= 1'b0;
            ctl0     <= '0;
            div      <= 8'd1;
            wide     <= 1'b0;
            space    <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                OFF_MCTL: begin
                    mode     <= op_mode_e'(bus_wdata[7:6]);
                    stop_req <= bus_wdata[1];
                end
                OFF_CTL0:  ctl0 <= bus_wdata[15:0];
                OFF_CTL1: if (mode == MODE_CONFIG) begin
                    div  <= bus_wdata[15:8];
                    wide <= (bus_wdata[4:0] == 5'd16);
                end
                OFF_SPACE: space <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    // sticky overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ovr <= 1'b0;
        else if (clr)                ovr <= 1'b0;
        else if (rx_push && rx_full) ovr <= 1'b1;
    end

    spi_host_fifo #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(tx_push), .din(bus_wdata[WORD_MAX-1:0]),
        .pop(tx_pop), .dout(tx_dout),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spi_host_fifo #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_dout),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spi_host_engine #(.MAXW(WORD_MAX), .DIVW(8)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg(cfg),
        .tx_avail(!tx_empty), .tx_word(tx_dout), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .sck(sck), .mosi(mosi), .miso(miso), .idle(eng_idle)
    );

    assign tx_cnt3 = 3'(tx_cnt);
    assign rx_cnt3 = 3'(rx_cnt);
    assign rx_flag = (rx_cnt3 >= ({1'b0, ctl0[13:12]} + 3'd1));
    assign tx_flag = (tx_cnt3 <= {1'b0, ctl0[15:14]});
    assign irq     = rx_flag && ctl0[9];

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_MCTL:  bus_rdata = {24'd0, mode, 4'd0, stop_req, 1'b0};
            OFF_CTL0:  bus_rdata = {16'd0, ctl0};
            OFF_CTL1:  bus_rdata = {16'd0, div, 3'd0, (wide ? 5'd16 : 5'd8)};
            OFF_SPACE: bus_rdata = {24'd0, space};
            OFF_STAT:  bus_rdata = {16'd0, tx_flag, rx_flag, tx_cnt3, rx_cnt3,
                                    ovr, 4'd0, (eng_idle && tx_empty),
                                    !tx_full, !rx_empty};
            OFF_DATA:  bus_rdata = {{(32-WORD_MAX){1'b0}}, rx_dout};
            default:   bus_rdata = '0;
        endcase
    end

    // R2
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFF_CTL1 && mode != MODE_CONFIG)
            |=> ($stable(div) && $stable(wide)));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && eng_idle) |=> eng_idle);

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_cnt3 > {1'b0, ctl0[13:12]}));

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr) |=> ovr);

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tx_cnt == '0 && rx_cnt == '0 && !ovr));
endmodule

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sck, mosi, miso;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign miso = mosi;

    spi_host_ctrl u_spi_host_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
    );

    // rising-edge monitor
    int          cyc = 0;
    logic [7:0]  rn = '0;
    int          rise_t [256];
    logic        rise_b [256];
    logic        rise_c [256];
    logic        sck_p = 1'b0, mosi_p = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sck && !sck_p) begin
            rise_t[rn] = cyc;
            rise_b[rn] = mosi;
            rise_c[rn] = (mosi != mosi_p);
            rn = rn + 8'd1;
        end
        sck_p = sck;
        mosi_p = mosi;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(5'h14, s);
            if (s[2]) break;
        end
    endtask

    task automatic setup(input logic [15:0] c0, input logic [15:0] c1,
                         input logic [7:0] sp);
        wr(5'h00, 32'h41);
        wr(5'h04, {16'd0, c0});
        wr(5'h08, {16'd0, c1});
        wr(5'h0C, {24'd0, sp});
    endtask

    task automatic xfer(input logic [15:0] w, output logic [31:0] r,
                        output logic [7:0] base);
        base = rn;
        wr(5'h18, {16'd0, w});
        wr(5'h00, 32'h80);
        wait_idle();
        rd(5'h18, r);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(5'h00, d); chk("R1", "mode reg", d, 32'h40);
        rd(5'h08, d); chk("R1", "clk/len reg", d, 32'h0108);
        rd(5'h14, d); chk("R1", "status", d, 32'h8006);
        chk("R1", "irq", {31'd0, irq}, 0);
        chk("R1", "sck", {31'd0, sck}, 0);
    endtask

    task automatic t_cfg_lock();
        logic [31:0] d;
        setup(16'h0000, 16'h0310, 8'd0);
        rd(5'h08, d); chk("R2", "write in config", d, 32'h0310);
        wr(5'h00, 32'h80);
        wr(5'h08, 32'h0708);
        rd(5'h08, d); chk("R2", "write in active ignored", d, 32'h0310);
    endtask

    task automatic t_mode_gate();
        logic [31:0] d;
        logic [7:0] b;
        setup(16'h0000, 16'h0108, 8'd0);
        b = rn;
        wr(5'h18, 32'h5A);
        repeat (40) @(negedge clk);
        chk("R3", "no clock in config", {24'd0, rn - b}, 0);
        rd(5'h14, d); chk("R3", "word held in config", {29'd0, d[13:11]}, 1);
        wr(5'h00, 32'h82);
        repeat (40) @(negedge clk);
        chk("R3", "no clock with stop", {24'd0, rn - b}, 0);
        wr(5'h00, 32'h80);
        wait_idle();
        chk("R3", "eight edges once running", {24'd0, rn - b}, 8);
        rd(5'h18, d); chk("R7", "loopback byte", d, 32'h5A);
    endtask

    task automatic t_period();
        logic [31:0] d;
        logic [7:0] b;
        setup(16'h0000, 16'h0308, 8'd0);
        xfer(16'h3C, d, b);
        chk("R4", "period n=3", rise_t[8'(b+1)] - rise_t[b], 4);
        setup(16'h0000, 16'h0008, 8'd0);
        xfer(16'hC3, d, b);
        chk("R4", "period n=0 acts as 1", rise_t[8'(b+1)] - rise_t[b], 2);
        chk("R7", "loopback at fastest rate", d, 32'hC3);
    endtask

    task automatic t_order();
        logic [31:0] d;
        logic [7:0] b;
        setup(16'h0004, 16'h0108, 8'd0);
        xfer(16'h01, d, b);
        chk("R6", "msb first: first bit", {31'd0, rise_b[b]}, 0);
        chk("R6", "msb first: last bit", {31'd0, rise_b[8'(b+7)]}, 1);
        chk("R7", "msb first loopback", d, 32'h01);
        setup(16'h0000, 16'h0108, 8'd0);
        xfer(16'h01, d, b);
        chk("R6", "lsb first: first bit", {31'd0, rise_b[b]}, 1);
        xfer(16'h1234, d, b);
        chk("R6", "narrow uses low byte", d, 32'h34);
        setup(16'h0004, 16'h0110, 8'd0);
        xfer(16'hA5C3, d, b);
        chk("R7", "16-bit msb loopback", d, 32'hA5C3);
        chk("R6", "16-bit edge count", {24'd0, rn - b}, 16);
        setup(16'h0000, 16'h0110, 8'd0);
        xfer(16'h8E71, d, b);
        chk("R7", "16-bit lsb loopback", d, 32'h8E71);
    endtask

    task automatic t_phase();
        logic [31:0] d;
        logic [7:0] b;
        int n;
        setup(16'h0001, 16'h0108, 8'd0);
        @(negedge clk);
        chk("R5", "idle level high", {31'd0, sck}, 1);
        xfer(16'h5A, d, b);
        chk("R5", "loopback cpol=1", d, 32'h5A);
        setup(16'h0000, 16'h0108, 8'd0);
        xfer(16'h55, d, b);
        n = 0;
        for (int k = 0; k < 8; k++) n += int'(rise_c[8'(b+k)]);
        chk("R5", "phase 0: data steady at rising edge", n, 0);
        setup(16'h0002, 16'h0108, 8'd0);
        xfer(16'h55, d, b);
        n = 0;
        for (int k = 0; k < 8; k++) n += int'(rise_c[8'(b+k)]);
        chk("R5", "phase 1: data moves on rising edge", n, 8);
        chk("R5", "loopback phase 1", d, 32'h55);
    endtask

    task automatic t_fifo();
        logic [31:0] d;
        setup(16'hC000, 16'h0108, 8'd0);
        for (int i = 0; i < 5; i++) wr(5'h18, 32'h10 + i);
        rd(5'h14, d);
        chk("R8", "tx count saturates", {29'd0, d[13:11]}, 4);
        chk("R12", "tx not ready", {31'd0, d[1]}, 0);
        chk("R12", "tx level flag 4<=3", {31'd0, d[15]}, 0);
        chk("R12", "not idle", {31'd0, d[2]}, 0);
        wr(5'h00, 32'h41);
        rd(5'h14, d);
        chk("R11", "clear empties tx", {29'd0, d[13:11]}, 0);
        wr(5'h18, 32'h11); wr(5'h18, 32'h22); wr(5'h18, 32'h33);
        wr(5'h00, 32'h80);
        wait_idle();
        rd(5'h14, d);
        chk("R8", "rx count", {29'd0, d[10:8]}, 3);
        chk("R12", "rx ready", {31'd0, d[0]}, 1);
        rd(5'h18, d); chk("R8", "order 1", d, 32'h11);
        rd(5'h18, d); chk("R8", "order 2", d, 32'h22);
        rd(5'h18, d); chk("R8", "order 3", d, 32'h33);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        setup(16'h2200, 16'h0108, 8'd0);
        wr(5'h18, 32'hA1); wr(5'h18, 32'hA2);
        wr(5'h00, 32'h80);
        wait_idle();
        rd(5'h14, d);
        chk("R9", "flag below level", {31'd0, d[14]}, 0);
        chk("R9", "irq below level", {31'd0, irq}, 0);
        wr(5'h18, 32'hA3);
        wait_idle();
        rd(5'h14, d);
        chk("R9", "flag at level", {31'd0, d[14]}, 1);
        chk("R9", "irq at level", {31'd0, irq}, 1);
        rd(5'h18, d);
        @(negedge clk);
        chk("R9", "irq drops after pop", {31'd0, irq}, 0);
        wr(5'h04, 32'h0000);
        rd(5'h14, d);
        chk("R9", "level 1 flag", {31'd0, d[14]}, 1);
        chk("R9", "irq masked", {31'd0, irq}, 0);
    endtask

    task automatic t_ovr();
        logic [31:0] d;
        setup(16'h0000, 16'h0108, 8'd0);
        for (int i = 0; i < 4; i++) wr(5'h18, 32'hB0 + i);
        wr(5'h00, 32'h80);
        wait_idle();
        rd(5'h14, d);
        chk("R10", "no overrun yet", {31'd0, d[7]}, 0);
        wr(5'h18, 32'hBF);
        wait_idle();
        rd(5'h14, d);
        chk("R10", "overrun set", {31'd0, d[7]}, 1);
        chk("R10", "rx count stays full", {29'd0, d[10:8]}, 4);
        rd(5'h18, d); chk("R10", "oldest word kept", d, 32'hB0);
        rd(5'h14, d);
        chk("R10", "overrun sticky", {31'd0, d[7]}, 1);
        wr(5'h00, 32'h41);
        rd(5'h14, d);
        chk("R11", "clear drops overrun", {31'd0, d[7]}, 0);
        chk("R11", "clear empties rx", {29'd0, d[10:8]}, 0);
    endtask

    task automatic t_space();
        logic [31:0] d;
        logic [7:0] b;
        setup(16'h0000, 16'h0108, 8'd0);
        b = rn;
        wr(5'h18, 32'h0F); wr(5'h18, 32'hF0);
        wr(5'h00, 32'h80);
        wait_idle();
        chk("R13", "boundary spacing F=0", rise_t[8'(b+8)] - rise_t[8'(b+7)], 3);
        rd(5'h18, d); rd(5'h18, d);
        chk("R7", "second word", d, 32'hF0);
        setup(16'h0000, 16'h0108, 8'd6);
        b = rn;
        wr(5'h18, 32'h0F); wr(5'h18, 32'hF0);
        wr(5'h00, 32'h80);
        wait_idle();
        chk("R13", "boundary spacing F=6", rise_t[8'(b+8)] - rise_t[8'(b+7)], 9);
        chk("R13", "spacing within word", rise_t[8'(b+1)] - rise_t[b], 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_cfg_lock();
        t_mode_gate();
        t_period();
        t_order();
        t_phase();
        t_fifo();
        t_irq();
        t_ovr();
        t_space();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule